// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Selectable Flags

This block is a first-in first-out buffer with separate write and read clocks. Words enter on the write clock and leave on the read clock. Each status flag is produced in the clock domain of the side that uses it. The pointers cross between the domains as Gray codes through two-stage synchronizers.

A mode bit is captured while master reset is held. The mode sets the read behaviour and the meaning of the two main flags.

- **Standard mode:** a word sits in memory until a read request fetches it. The flags report empty and full.
- **Fall-through mode:** the oldest word is presented at the output by itself. The flags report output-ready and input-ready.

Two threshold flags compare the fill level against offsets that arrive as inputs.

A shared control pin does one of two jobs, chosen by a select input:

- **Partial reset:** flushes the stored data and keeps the captured mode.
- **Retransmit:** rewinds only the read side, so the data stored since the last reset can be read out again.

Top module: `dcf_top`

## Requirements
- R1: The read mode is taken from `fwft_sel` (0 = standard, 1 = fall-through) on read and write clock edges where `mrst` is high. Changes of `fwft_sel` while `mrst` is low have no effect.
- R2: In standard mode, a word written into an empty FIFO stays stored until a read is accepted. An accepted read (`rd_en` high while `flag_out` is 0) puts the oldest word on `dout` at that read-clock edge, and words leave in write order.
- R3: In fall-through mode, the oldest stored word appears on `dout` with `flag_out` = 1 and no read request. `dout` holds while `rd_en` is low. Each later word needs `rd_en` high while `flag_out` is 1.
- R4: `flag_in` is 1 when DEPTH words are stored in standard mode (full). In fall-through mode it is 1 when space remains (input-ready). `flag_out` is 1 when nothing is stored in standard mode (empty). In fall-through mode it is 1 when a valid word is on `dout` (output-ready).
- R5: `almost_empty` is 1 when the read-side level is at most `ae_off`. `almost_full` is 1 when the write-side level is at least DEPTH minus `af_off`. In fall-through mode the read-side level counts the word held on `dout`.
- R6: Read-side flags follow the write pointer through two read-clock register stages. A write into an empty FIFO still shows empty after the first read-clock edge that follows it, and shows non-empty after the second.
- R7: A write while full (`flag_in` says no space) and a read while empty (or while not output-ready) are ignored. No word is lost, duplicated or skipped.
- R8: With `rt_mode` = 0, `prst_rt` = 1 is a partial reset. Both pointers return to the first location, the FIFO reads as empty, and the captured mode and the offsets are kept.
- R9: With `rt_mode` = 1, `prst_rt` = 1 is a retransmit. Only the read pointer returns to the first location, so reads restart at the first word written since the last reset. The rewind applies from the next read-clock cycle, and the write pointer is unchanged.
- R10: After master reset, the FIFO is empty. In standard mode this means `flag_out` = 1, `flag_in` = 0, `almost_empty` = 1 and `almost_full` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, sampled in both domains |
| prst_rt | input | 1 | Partial reset or retransmit request, active high |
| rt_mode | input | 1 | 1 selects retransmit for `prst_rt`, 0 selects partial reset |
| fwft_sel | input | 1 | Mode bit captured during master reset |
| ae_off | input | AW+1 | Almost-empty offset |
| af_off | input | AW+1 | Almost-full offset |
| wr_en | input | 1 | Write request |
| wdata | input | W | Write data |
| flag_in | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_full | output | 1 | Level within `af_off` of full |
| rd_en | input | 1 | Read request |
| dout | output | W | Read data |
| flag_out | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Level at or below `ae_off` |

## Verification
The hardest situation to reach from the ports is a retransmit issued after part of the data has been read. Reads must then restart at the first word while the write side keeps its place. The directed part of the stimulus writes six words, reads three, issues the rewind, and reads immediately. It then checks the replay and a word written afterwards.

Filling to exactly DEPTH and pushing extra writes into a full FIFO is also directed, because random traffic with balanced rates seldom stays full. The random phases swing the write and read rates from write-heavy to read-heavy in both modes, so both boundaries are crossed repeatedly.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        RD_STD  = 1'b0,
        RD_FWFT = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic full;
        logic afull;
    } wr_stat_t;

    typedef struct packed {
        logic empty;
        logic aempty;
    } rd_stat_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int s = 1; s < 32; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          fwft_in,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    input  logic [AW:0]   af_off,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW:0]   wbin,
    output rd_mode_e      mode,
    output logic          flag_in,
    output logic          almost_full
);
    localparam int LW = AW + 1;
    localparam logic [AW:0] DEPTH_L = {1'b1, {AW{1'b0}}};

    logic [AW:0] rbin_s;
    logic [AW:0] level;
    wr_stat_t    st;

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode <= rd_mode_e'(fwft_in);
            wbin <= '0;
        end else if (prst) begin
            wbin <= '0;
        end else if (we) begin
            wbin <= wbin + 1'b1;
        end
    end

    always_comb begin
        rbin_s   = LW'(from_gray(32'(rgray_s)));
        level    = wbin - rbin_s;
        st.full  = (level >= DEPTH_L);
        st.afull = ({1'b0, level} + {1'b0, af_off}) >= {1'b0, DEPTH_L};
    end

    assign we          = wr_en && !st.full && !mrst && !prst;
    assign waddr       = wbin[AW-1:0];
    assign wgray       = LW'(to_gray(32'(wbin)));
    assign flag_in     = (mode == RD_FWFT) ? !st.full : st.full;
    assign almost_full = st.afull;
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          rt,
    input  logic          fwft_in,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [AW:0]   ae_off,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [AW:0]   rbin,
    output rd_mode_e      mode,
    output logic          flag_out,
    output logic          almost_empty
);
    localparam int LW = AW + 1;

    logic [AW:0] wbin_s;
    logic [AW:0] level_mem;
    logic [AW:0] level_all;
    logic        ov;
    logic        fetch;
    rd_stat_t    st;

    always_comb begin
        wbin_s    = LW'(from_gray(32'(wgray_s)));
        level_mem = wbin_s - rbin;
        level_all = level_mem + {{AW{1'b0}}, ov};
        st.empty  = (level_mem == '0);
        st.aempty = (level_all <= ae_off);
        if (mode == RD_FWFT) fetch = !st.empty && (!ov || rd_en);
        else                 fetch = !st.empty && rd_en;
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode <= rd_mode_e'(fwft_in);
            rbin <= '0;
            ov   <= 1'b0;
        end else if (prst || rt) begin
            rbin <= '0;
            ov   <= 1'b0;
        end else begin
            if (fetch) rbin <= rbin + 1'b1;
            if (mode == RD_FWFT) begin
                if (fetch)      ov <= 1'b1;
                else if (rd_en) ov <= 1'b0;
            end
        end
    end

    assign re           = fetch && !mrst && !prst && !rt;
    assign raddr        = rbin[AW-1:0];
    assign rgray        = LW'(to_gray(32'(rbin)));
    assign flag_out     = (mode == RD_FWFT) ? ov : st.empty;
    assign almost_empty = st.aempty;
endmodule

// File: rtl/dcf_top.sv
module dcf_top
    import dcf_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         mrst,
    input  logic         prst_rt,
    input  logic         rt_mode,
    input  logic         fwft_sel,
    input  logic [AW:0]  ae_off,
    input  logic [AW:0]  af_off,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic         flag_in,
    output logic         almost_full,
    input  logic         rd_en,
    output logic [W-1:0] dout,
    output logic         flag_out,
    output logic         almost_empty
);
    logic          prst;
    logic          rt;
    logic          we;
    logic          re;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW:0]   wgray;
    logic [AW:0]   rgray;
    logic [AW:0]   wgray_s;
    logic [AW:0]   rgray_s;
    logic [AW:0]   w_bin;
    logic [AW:0]   r_bin;
    rd_mode_e      w_mode;
    rd_mode_e      r_mode;
    logic          w_fwft;
    logic          r_fwft;

    assign prst   = prst_rt && !rt_mode;
    assign rt     = prst_rt && rt_mode;
    assign w_fwft = (w_mode == RD_FWFT);
    assign r_fwft = (r_mode == RD_FWFT);

    dcf_wside #(.AW(AW)) u_wside (
        .clk(wclk), .mrst(mrst), .prst(prst), .fwft_in(fwft_sel),
        .wr_en(wr_en), .rgray_s(rgray_s), .af_off(af_off),
        .we(we), .waddr(waddr), .wgray(wgray), .wbin(w_bin),
        .mode(w_mode), .flag_in(flag_in), .almost_full(almost_full)
    );

    dcf_rside #(.AW(AW)) u_rside (
        .clk(rclk), .mrst(mrst), .prst(prst), .rt(rt), .fwft_in(fwft_sel),
        .rd_en(rd_en), .wgray_s(wgray_s), .ae_off(ae_off),
        .re(re), .raddr(raddr), .rgray(rgray), .rbin(r_bin),
        .mode(r_mode), .flag_out(flag_out), .almost_empty(almost_empty)
    );

    dcf_sync #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst(mrst || prst), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst(mrst || prst), .d(rgray), .q(rgray_s)
    );

    dcf_store #(.W(W), .AW(AW)) u_store (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
        .rclk(rclk), .re(re), .raddr(raddr), .rdata(dout)
    );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input logic         wclk,
    input logic         rclk,
    input logic         mrst,
    input logic         prst_rt,
    input logic         rt_mode,
    input logic         wr_en,
    input logic         rd_en,
    input logic         flag_in,
    input logic         flag_out,
    input logic         almost_full,
    input logic         almost_empty,
    input logic [W-1:0] dout,
    input logic [AW:0]  w_bin,
    input logic [AW:0]  r_bin,
    input logic         w_fwft,
    input logic         r_fwft
);
    // R1
    mode_hold_chk: assert property (@(posedge rclk) disable iff (mrst)
        1'b1 |=> $stable(r_fwft));

    // R3
    fwft_hold_chk: assert property (@(posedge rclk) disable iff (mrst)
        (r_fwft && flag_out && !rd_en && !prst_rt) |=> (flag_out && $stable(dout)));

    // R5
    empty_ae_chk: assert property (@(posedge rclk) disable iff (mrst)
        (!r_fwft && flag_out) |-> almost_empty);

    // R5
    full_af_chk: assert property (@(posedge wclk) disable iff (mrst)
        (!w_fwft && flag_in) |-> almost_full);

    // R7
    no_overflow_chk: assert property (@(posedge wclk) disable iff (mrst)
        (wr_en && !prst_rt && (flag_in != w_fwft)) |=> $stable(w_bin));

    // R7
    no_underflow_chk: assert property (@(posedge rclk) disable iff (mrst)
        (rd_en && !r_fwft && flag_out && !prst_rt) |=> $stable(r_bin));

    // R8
    prst_clear_chk: assert property (@(posedge wclk) disable iff (mrst)
        (prst_rt && !rt_mode) |=> (w_bin == '0));

    // R9
    rewind_chk: assert property (@(posedge rclk) disable iff (mrst)
        (prst_rt && rt_mode) |=> (r_bin == '0));
endmodule

bind dcf_top dcf_chk #(.W(W), .AW(AW)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst_rt(prst_rt), .rt_mode(rt_mode),
    .wr_en(wr_en), .rd_en(rd_en), .flag_in(flag_in), .flag_out(flag_out),
    .almost_full(almost_full), .almost_empty(almost_empty), .dout(dout),
    .w_bin(w_bin), .r_bin(r_bin), .w_fwft(w_fwft), .r_fwft(r_fwft)
);

// File: tb/sim_dcf_top.sv
module sim_dcf_top;
    localparam int W     = 16;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst = 1'b1;
    logic          prst_rt = 1'b0;
    logic          rt_mode = 1'b0;
    logic          fwft_sel = 1'b0;
    logic [AW:0]   ae_off = 5'd3;
    logic [AW:0]   af_off = 5'd2;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic          flag_in;
    logic          almost_full;
    logic          rd_en = 1'b0;
    logic [W-1:0]  dout;
    logic          flag_out;
    logic          almost_empty;

    always #5 wclk = ~wclk;
    initial begin
        #1;
        forever #7 rclk = ~rclk;
    end

    dcf_top #(.W(W), .AW(AW)) u0 (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst_rt(prst_rt), .rt_mode(rt_mode),
        .fwft_sel(fwft_sel), .ae_off(ae_off), .af_off(af_off), .wr_en(wr_en),
        .wdata(wdata), .flag_in(flag_in), .almost_full(almost_full), .rd_en(rd_en),
        .dout(dout), .flag_out(flag_out), .almost_empty(almost_empty)
    );

    int           n_chk = 0;
    int           n_fail = 0;
    bit           fwft_b = 1'b0;
    bit           pend = 1'b0;
    logic [W-1:0] q[$];
    logic [W-1:0] hist[$];

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_mrst(input bit m);
        @(negedge rclk);
        mrst = 1'b1; fwft_sel = m; fwft_b = m;
        wr_en = 1'b0; rd_en = 1'b0; prst_rt = 1'b0; rt_mode = 1'b0;
        repeat (4) @(posedge rclk);
        @(negedge rclk);
        mrst = 1'b0;
        q.delete(); hist.delete(); pend = 1'b0;
        repeat (3) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic wr_cycle(input bit en, input logic [W-1:0] d);
        @(negedge wclk);
        wr_en = en; wdata = d;
        if (en && (fwft_b ? flag_in : !flag_in)) begin
            q.push_back(d);
            hist.push_back(d);
        end
    endtask

    task automatic rd_cycle(input bit en);
        @(negedge rclk);
        if (pend) begin
            if (q.size() == 0) chk(1'b0, "R2 read data with empty model", dout, '0);
            else begin
                chk(dout === q[0], "R2 standard read order", dout, q[0]);
                void'(q.pop_front());
            end
            pend = 1'b0;
        end
        if (fwft_b) begin
            if (flag_out) begin
                if (q.size() == 0) chk(1'b0, "R3 output-ready with empty model", dout, '0);
                else begin
                    chk(dout === q[0], "R3 fall-through data", dout, q[0]);
                    if (en) void'(q.pop_front());
                end
            end
        end else begin
            pend = en && !flag_out;
        end
        rd_en = en;
    endtask

    task automatic drain();
        for (int i = 0; i < 60; i++) rd_cycle(1'b1);
        rd_cycle(1'b0);
        settle();
        chk(q.size() == 0, "R7 all accepted words read once", W'(q.size()), '0);
        chk(flag_out == !fwft_b, "R4 drained flag_out", W'(flag_out), W'(!fwft_b));
    endtask

    task automatic rand_phase(input bit m);
        do_mrst(m);
        fwft_sel = ~m;
        settle();
        chk(flag_in == m, "R1 mode kept after fwft_sel change", W'(flag_in), W'(m));
        fork
            begin
                for (int i = 0; i < 600; i++)
                    wr_cycle(($urandom % 100) < ((i < 300) ? 85 : 25), W'($urandom));
                wr_cycle(1'b0, '0);
            end
            begin
                for (int i = 0; i < 430; i++)
                    rd_cycle(($urandom % 100) < ((i < 215) ? 25 : 90));
                rd_cycle(1'b0);
            end
        join
        drain();
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R10: reset state in standard mode
        do_mrst(1'b0);
        chk(flag_out == 1'b1, "R10 empty after reset", W'(flag_out), 1);
        chk(flag_in == 1'b0, "R10 not full after reset", W'(flag_in), 0);
        chk(almost_empty == 1'b1, "R10 almost_empty after reset", W'(almost_empty), 1);
        chk(almost_full == 1'b0, "R10 almost_full after reset", W'(almost_full), 0);

        // R6: two read-clock stages before empty clears
        @(negedge wclk);
        wr_en = 1'b1; wdata = 16'hA001;
        q.push_back(16'hA001); hist.push_back(16'hA001);
        @(posedge wclk);
        #1 wr_en = 1'b0;
        @(posedge rclk);
        @(negedge rclk);
        chk(flag_out == 1'b1, "R6 still empty after first read edge", W'(flag_out), 1);
        @(posedge rclk);
        @(negedge rclk);
        chk(flag_out == 1'b0, "R6 not empty after second read edge", W'(flag_out), 0);
        settle();
        chk(flag_out == 1'b0, "R2 word stays without read", W'(flag_out), 0);

        // R5: thresholds (ae_off = 3, af_off = 2, DEPTH = 16)
        for (int i = 0; i < 2; i++) wr_cycle(1'b1, W'(16'hB000 + i));
        wr_cycle(1'b0, '0);
        settle();
        chk(almost_empty == 1'b1, "R5 level 3 almost empty", W'(almost_empty), 1);
        wr_cycle(1'b1, 16'hB010);
        wr_cycle(1'b0, '0);
        settle();
        chk(almost_empty == 1'b0, "R5 level 4 not almost empty", W'(almost_empty), 0);
        for (int i = 0; i < 9; i++) wr_cycle(1'b1, W'(16'hC000 + i));
        wr_cycle(1'b0, '0);
        settle();
        chk(almost_full == 1'b0, "R5 level 13 not almost full", W'(almost_full), 0);
        wr_cycle(1'b1, 16'hC100);
        wr_cycle(1'b0, '0);
        settle();
        chk(almost_full == 1'b1, "R5 level 14 almost full", W'(almost_full), 1);
        chk(flag_in == 1'b0, "R4 level 14 not full", W'(flag_in), 0);
        for (int i = 0; i < 2; i++) wr_cycle(1'b1, W'(16'hC200 + i));
        wr_cycle(1'b0, '0);
        settle();
        chk(flag_in == 1'b1, "R4 full at DEPTH", W'(flag_in), 1);
        chk(W'(q.size()) == W'(DEPTH), "R4 model holds DEPTH", W'(q.size()), W'(DEPTH));

        // R7: writes while full are dropped
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, W'(16'hDEAD + i));
        wr_cycle(1'b0, '0);
        settle();
        chk(flag_in == 1'b1, "R7 still full after extra writes", W'(flag_in), 1);
        drain();

        // R7: reads while empty are dropped
        for (int i = 0; i < 3; i++) rd_cycle(1'b1);
        rd_cycle(1'b0);
        wr_cycle(1'b1, 16'h5A5A);
        wr_cycle(1'b0, '0);
        settle();
        drain();

        // R9: retransmit after partial read
        do_mrst(1'b0);
        for (int i = 0; i < 6; i++) wr_cycle(1'b1, W'(16'h7100 + i));
        wr_cycle(1'b0, '0);
        settle();
        for (int i = 0; i < 3; i++) rd_cycle(1'b1);
        rd_cycle(1'b0);
        chk(q.size() == 3, "R9 three words read before rewind", W'(q.size()), 3);
        @(negedge rclk); rt_mode = 1'b1;
        @(negedge rclk); prst_rt = 1'b1;
        @(negedge rclk); prst_rt = 1'b0;
        q = hist;
        rd_cycle(1'b1);
        rd_cycle(1'b0);
        chk(q.size() == 5, "R9 first word replayed next cycle", W'(q.size()), 5);
        drain();
        wr_cycle(1'b1, 16'h7200);
        wr_cycle(1'b0, '0);
        settle();
        drain();
        rt_mode = 1'b0;

        // R3 / R8: fall-through and partial reset
        do_mrst(1'b1);
        fwft_sel = 1'b0;
        chk(flag_out == 1'b0, "R4 not output-ready after reset", W'(flag_out), 0);
        chk(flag_in == 1'b1, "R4 input-ready after reset", W'(flag_in), 1);
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, W'(16'h9300 + i));
        wr_cycle(1'b0, '0);
        settle();
        chk(flag_out == 1'b1, "R3 first word falls through", W'(flag_out), 1);
        chk(dout === q[0], "R3 first word on output", dout, q[0]);
        repeat (5) @(negedge rclk);
        chk(dout === q[0], "R3 output holds without read", dout, q[0]);
        chk(almost_empty == 1'b1, "R5 staged word counted, level 3", W'(almost_empty), 1);
        rd_cycle(1'b1);
        rd_cycle(1'b0);
        @(negedge rclk); prst_rt = 1'b1;
        repeat (3) @(negedge rclk);
        prst_rt = 1'b0;
        q.delete(); hist.delete();
        settle();
        chk(flag_out == 1'b0, "R8 flushed, not output-ready", W'(flag_out), 0);
        chk(flag_in == 1'b1, "R8 mode kept, input-ready", W'(flag_in), 1);
        wr_cycle(1'b1, 16'h9400);
        wr_cycle(1'b0, '0);
        settle();
        chk(flag_out == 1'b1, "R8 fall-through kept after flush", W'(flag_out), 1);
        chk(dout === 16'h9400, "R8 new word after flush", dout, 16'h9400);
        drain();

        // Random traffic in both modes
        rand_phase(1'b0);
        rand_phase(1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule